// File: doc/BRIEF.md
# Ballast Supply Power-Mode Sequencer

This block steps a lamp-ballast controller through its four supply states and drives the enables that go with each. It watches digital comparator flags for the supply rail and for the microcontroller reference, and it watches the low-side and high-side half-bridge command inputs that the microcontroller sends. From these it decides when the high-voltage start-up generator conducts, how much current the reference may source, and whether the charge regulator, the overcurrent logic and the gate drivers are active.

The states and transitions are: STARTUP (generator on, reference off with its sink clamp) goes to SAVE when the rail crosses the turn-on level. SAVE keeps the rail between the save level and the turn-on level by gating the generator, and goes to OPERATE once it has dwelt long enough, the reference is above 3.0 V, and the high-side command falls. OPERATE returns to SAVE when the low-side command stops toggling for too long, and goes to SHUTDOWN on a rail or reference undervoltage. SHUTDOWN goes to SAVE when the rail reaches the turn-on level. SAVE and SHUTDOWN both fall back to STARTUP when the rail drops below the reference-off level.

Top module: `ballast_pwr_seq`

## Requirements
- R1: While `rst` is sampled high the sequencer enters STARTUP; in STARTUP `hv_gen_en`=1, `ref_mode`=0 and `reg_en`, `ocp_en`, `drv_en` are 0.
- R2: STARTUP stays put while `vcc_ge_on` is 0 and moves to SAVE on the clock edge that samples `vcc_ge_on`=1.
- R3: In SAVE the generator gate is cleared when `vcc_ge_on` is 1, set when `vcc_ge_sm` is 0 (and `vcc_ge_on` 0), and held otherwise; it is 1 out of reset.
- R4: In SAVE `ref_mode`=1 (low current) and `reg_en`, `ocp_en`, `drv_en` are 0.
- R5: SAVE moves to OPERATE only when it has spent at least DWELL_CYC cycles in SAVE, `ref_gt_3v` is 1, and a falling edge of the synchronised `hsi` is seen (SYNC_STAGES+1 edges after the pin falls).
- R6: In OPERATE `hv_gen_en`=0, `ref_mode`=2 (high current) and `reg_en`, `ocp_en`, `drv_en` are 1.
- R7: In OPERATE, WDOG_CYC consecutive cycles with no edge on the synchronised `lsi` return the sequencer to SAVE; every edge restarts the count.
- R8: In OPERATE, `vcc_lt_off`=1 or `ref_lt_2v`=1 moves to SHUTDOWN, taking priority over the activity timeout.
- R9: In SHUTDOWN `hv_gen_en`=1, `ref_mode`=1 and the three enables are 0; it moves to SAVE when `vcc_ge_on` is 1.
- R10: From SAVE or SHUTDOWN, `vcc_lt_refoff`=1 moves to STARTUP, taking priority over every other exit.
- R11: `ref_mode` encodes 0 = off with sink clamp, 1 = low-current source, 2 = high-current source; 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ge_on | input | 1 | Supply at or above turn-on level |
| vcc_ge_sm | input | 1 | Supply at or above save-mode level |
| vcc_lt_off | input | 1 | Supply below turn-off level |
| vcc_lt_refoff | input | 1 | Supply below reference-off level |
| ref_gt_3v | input | 1 | Reference above 3.0 V |
| ref_lt_2v | input | 1 | Reference below 2.0 V |
| lsi | input | 1 | Low-side command from the microcontroller (asynchronous) |
| hsi | input | 1 | High-side command from the microcontroller (asynchronous) |
| hv_gen_en | output | 1 | High-voltage start-up generator enable |
| ref_mode | output | 2 | Reference current mode (R11 encoding) |
| reg_en | output | 1 | Supply charge regulator enable |
| ocp_en | output | 1 | Overcurrent logic enable |
| drv_en | output | 1 | Gate driver enable |

## Verification
The assertions take the six comparator flags as already synchronous to `clk` and mutually consistent: `vcc_ge_on` implies `vcc_ge_sm`, and a rail below the turn-off or reference-off level is never also flagged above turn-on. The stimulus only changes flags on the falling clock edge and moves them as a real rail would, so no impossible flag combination is ever applied; only `lsi` and `hsi` are treated as asynchronous and go through the synchronisers. A behavioural model of the four states, dwell count, activity count and generator hysteresis is compared with every output on every clock.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_SAVE  = 2'd1,
        ST_OPER  = 2'd2,
        ST_SHUT  = 2'd3
    } pmode_t;

    typedef enum logic [1:0] {
        REF_OFF  = 2'd0,
        REF_LOW  = 2'd1,
        REF_HIGH = 2'd2
    } refmode_t;
endpackage

// File: rtl/bps_sync_edge.sv
module bps_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
    assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/bps_timer.sv
module bps_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)            cnt <= '0;
        else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == W'(LIMIT));

    // R5 / R7: a clear always restarts the window
    p_clear_restarts_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> !done);
endmodule

// File: rtl/ballast_pwr_seq.sv
module ballast_pwr_seq
    import bps_pkg::*;
#(
    parameter int DWELL_CYC   = 16,
    parameter int WDOG_CYC    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_ge_on,
    input  logic       vcc_ge_sm,
    input  logic       vcc_lt_off,
    input  logic       vcc_lt_refoff,
    input  logic       ref_gt_3v,
    input  logic       ref_lt_2v,
    input  logic       lsi,
    input  logic       hsi,
    output logic       hv_gen_en,
    output logic [1:0] ref_mode,
    output logic       reg_en,
    output logic       ocp_en,
    output logic       drv_en
);
    pmode_t   state_q, state_d;
    refmode_t ref_sel;
    logic     gen_q;
    logic     lsi_lvl, lsi_rise, lsi_fall, lsi_edge;
    logic     hsi_lvl, hsi_rise, hsi_fall;
    logic     dwell_done, wdog_done;
    logic     fault;

    bps_sync_edge #(.STAGES(SYNC_STAGES)) u_lsi_sync (
        .clk(clk), .rst(rst), .din(lsi),
        .level(lsi_lvl), .rise(lsi_rise), .fall(lsi_fall)
    );

    bps_sync_edge #(.STAGES(SYNC_STAGES)) u_hsi_sync (
        .clk(clk), .rst(rst), .din(hsi),
        .level(hsi_lvl), .rise(hsi_rise), .fall(hsi_fall)
    );

    assign lsi_edge = lsi_rise | lsi_fall;

    bps_timer #(.LIMIT(DWELL_CYC)) u_dwell (
        .clk(clk), .rst(rst), .clr(state_q != ST_SAVE), .done(dwell_done)
    );

    bps_timer #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk(clk), .rst(rst), .clr((state_q != ST_OPER) || lsi_edge), .done(wdog_done)
    );

    assign fault = vcc_lt_off | ref_lt_2v;

    // Generator hysteresis latch used while in SAVE
    always_ff @(posedge clk) begin
        if (rst)             gen_q <= 1'b1;
        else if (vcc_ge_on)  gen_q <= 1'b0;
        else if (!vcc_ge_sm) gen_q <= 1'b1;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: if (vcc_ge_on) state_d = ST_SAVE;
            ST_SAVE: begin
                if (vcc_lt_refoff)                             state_d = ST_START;
                else if (dwell_done && ref_gt_3v && hsi_fall)  state_d = ST_OPER;
            end
            ST_OPER: begin
                if (fault)          state_d = ST_SHUT;
                else if (wdog_done) state_d = ST_SAVE;
            end
            ST_SHUT: begin
                if (vcc_lt_refoff)  state_d = ST_START;
                else if (vcc_ge_on) state_d = ST_SAVE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_START;
        else     state_q <= state_d;
    end

    // Outputs per state
    always_comb begin
        hv_gen_en = 1'b0;
        ref_sel   = REF_OFF;
        reg_en    = 1'b0;
        ocp_en    = 1'b0;
        drv_en    = 1'b0;
        unique case (state_q)
            ST_START: hv_gen_en = 1'b1;
            ST_SAVE: begin
                hv_gen_en = gen_q;
                ref_sel   = REF_LOW;
            end
            ST_OPER: begin
                ref_sel = REF_HIGH;
                reg_en  = 1'b1;
                ocp_en  = 1'b1;
                drv_en  = 1'b1;
            end
            ST_SHUT: begin
                hv_gen_en = 1'b1;
                ref_sel   = REF_LOW;
            end
        endcase
    end

    assign ref_mode = ref_sel;

    // ---------------- assertions ----------------
    p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hv_gen_en && ref_mode == 2'd0 && !reg_en && !ocp_en && !drv_en));

    p_start_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && !vcc_ge_on) |=> (state_q == ST_START));

    p_save_gen_on_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAVE && !vcc_ge_sm && !vcc_ge_on) |=> (hv_gen_en || state_q != ST_SAVE));

    p_oper_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> $past(dwell_done && ref_gt_3v && hsi_fall));

    p_idle_return_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPER && wdog_done && !fault) |=> (state_q == ST_SAVE));

    p_fault_shut_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPER && fault) |=> (state_q == ST_SHUT && hv_gen_en && !drv_en));

    p_refoff_start_r10: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SAVE || state_q == ST_SHUT) && vcc_lt_refoff) |=> (state_q == ST_START));

    p_ref_code_r11: assert property (@(posedge clk) disable iff (rst)
        ref_mode != 2'd3);
endmodule

// File: tb/tb_ballast_pwr_seq.sv
module tb_ballast_pwr_seq;
    localparam int CLK_P  = 10;
    localparam int DWELL  = 16;
    localparam int WDOG   = 32;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ge_on = 0, vcc_ge_sm = 0, vcc_lt_off = 1, vcc_lt_refoff = 1;
    logic ref_gt_3v = 0, ref_lt_2v = 0, lsi = 0, hsi = 0;
    logic hv_gen_en, reg_en, ocp_en, drv_en;
    logic [1:0] ref_mode;

    int checks = 0;
    int failures = 0;
    bit done_run = 0;

    always #(CLK_P/2) clk = ~clk;

    ballast_pwr_seq #(.DWELL_CYC(DWELL), .WDOG_CYC(WDOG), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst),
        .vcc_ge_on(vcc_ge_on), .vcc_ge_sm(vcc_ge_sm), .vcc_lt_off(vcc_lt_off),
        .vcc_lt_refoff(vcc_lt_refoff), .ref_gt_3v(ref_gt_3v), .ref_lt_2v(ref_lt_2v),
        .lsi(lsi), .hsi(hsi),
        .hv_gen_en(hv_gen_en), .ref_mode(ref_mode), .reg_en(reg_en),
        .ocp_en(ocp_en), .drv_en(drv_en)
    );

    // ---------------- behavioural reference model ----------------
    // mode: 0 startup, 1 save, 2 operate, 3 shutdown
    int m_mode = 0;
    bit m_gen = 1;
    int m_save_cnt = 0;
    int m_idle_cnt = 0;
    bit hs_hist [0:SYNC];
    bit ls_hist [0:SYNC];

    initial begin
        for (int i = 0; i <= SYNC; i++) begin
            hs_hist[i] = 0;
            ls_hist[i] = 0;
        end
    end

    always @(posedge clk) begin
        int  nxt;
        bit  hs_fall_now, ls_edge_now;
        if (rst) begin
            m_mode = 0; m_gen = 1; m_save_cnt = 0; m_idle_cnt = 0;
            for (int i = 0; i <= SYNC; i++) begin
                hs_hist[i] = 0;
                ls_hist[i] = 0;
            end
        end else begin
            hs_fall_now = hs_hist[SYNC] && !hs_hist[SYNC-1];
            ls_edge_now = ls_hist[SYNC] != ls_hist[SYNC-1];
            nxt = m_mode;
            case (m_mode)
                0: if (vcc_ge_on) nxt = 1;
                1: if (vcc_lt_refoff) nxt = 0;
                   else if (m_save_cnt >= DWELL && ref_gt_3v && hs_fall_now) nxt = 2;
                2: if (vcc_lt_off || ref_lt_2v) nxt = 3;
                   else if (m_idle_cnt >= WDOG) nxt = 1;
                default: if (vcc_lt_refoff) nxt = 0;
                         else if (vcc_ge_on) nxt = 1;
            endcase
            m_save_cnt = (m_mode == 1) ? m_save_cnt + 1 : 0;
            m_idle_cnt = (m_mode != 2 || ls_edge_now) ? 0 : m_idle_cnt + 1;
            if (vcc_ge_on) m_gen = 0;
            else if (!vcc_ge_sm) m_gen = 1;
            for (int i = SYNC; i > 0; i--) begin
                hs_hist[i] = hs_hist[i-1];
                ls_hist[i] = ls_hist[i-1];
            end
            hs_hist[0] = hsi;
            ls_hist[0] = lsi;
            m_mode = nxt;
        end
    end

    function automatic logic [5:0] model_out();
        case (m_mode)
            0: return 6'b1_00_000;
            1: return {m_gen, 2'b01, 3'b000};
            2: return 6'b0_10_111;
            default: return 6'b1_01_000;
        endcase
    endfunction

    function automatic string mode_req(int m);
        case (m)
            0: return "R1/R2";
            1: return "R3/R4/R5";
            2: return "R6/R7/R8";
            default: return "R9/R10";
        endcase
    endfunction

    wire [5:0] dut_out = {hv_gen_en, ref_mode, reg_en, ocp_en, drv_en};

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (!done_run) begin
            checks++;
            if (dut_out !== model_out()) begin
                failures++;
                $display("FAIL %s cycle compare: actual=%b expected=%b",
                         mode_req(m_mode), dut_out, model_out());
            end
        end
    end

    task automatic chk(input string req, input logic [5:0] exp);
        checks++;
        if (dut_out !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, dut_out, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hsi_fall_pulse();
        hsi = 1; step(4);
        hsi = 0; step(4);
    endtask

    task automatic lsi_toggle(input int edges, input int gap);
        for (int k = 0; k < edges; k++) begin
            lsi = ~lsi;
            step(gap);
        end
    endtask

    task automatic finish_run();
        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    localparam logic [5:0] O_START  = 6'b1_00_000;
    localparam logic [5:0] O_SAVE0  = 6'b0_01_000;
    localparam logic [5:0] O_SAVE1  = 6'b1_01_000;
    localparam logic [5:0] O_OPER   = 6'b0_10_111;
    localparam logic [5:0] O_SHUT   = 6'b1_01_000;

    initial begin
        step(3);
        chk("R1 reset state", O_START);
        rst = 0;
        step(5);
        chk("R2 startup holds below turn-on", O_START);

        // rail rises past turn-on
        vcc_lt_refoff = 0; vcc_lt_off = 0; vcc_ge_sm = 1; vcc_ge_on = 1;
        ref_gt_3v = 1;
        step(1);
        chk("R2 startup to save, R3 gen off, R11 low code", O_SAVE0);

        // early high-side fall, dwell not met
        hsi_fall_pulse();
        chk("R5 no entry before dwell", O_SAVE0);

        // hysteresis
        vcc_ge_on = 0; step(2);
        chk("R3 hold off between levels", O_SAVE0);
        vcc_ge_sm = 0; step(2);
        chk("R3 gen on below save level", O_SAVE1);
        vcc_ge_sm = 1; step(2);
        chk("R3 hold on between levels", O_SAVE1);
        vcc_ge_on = 1; step(2);
        chk("R3 gen off at turn-on, R4 save outputs", O_SAVE0);

        step(DWELL + 2);
        ref_gt_3v = 0;
        hsi_fall_pulse();
        chk("R5 no entry with reference low", O_SAVE0);
        ref_gt_3v = 1;
        hsi_fall_pulse();
        chk("R5 entry on qualified fall, R6 operate outputs", O_OPER);

        lsi_toggle(6, WDOG / 2);
        chk("R7 activity keeps operate", O_OPER);
        step(WDOG + 6);
        chk("R7 idle timeout to save", O_SAVE0);

        // second entry then reference undervoltage
        step(DWELL + 2);
        hsi_fall_pulse();
        chk("R5 re-entry", O_OPER);
        lsi_toggle(3, 8);
        vcc_ge_on = 0;
        step(2);
        chk("R6 operate ignores turn-on flag", O_OPER);
        ref_lt_2v = 1; step(1);
        chk("R8 reference fault to shutdown, R9 outputs", O_SHUT);
        ref_lt_2v = 0; step(4);
        chk("R9 shutdown holds below turn-on", O_SHUT);
        vcc_ge_on = 1; step(1);
        chk("R9 shutdown to save", O_SAVE0);

        // supply fault, then reference-off fall-back
        step(DWELL + 2);
        hsi_fall_pulse();
        chk("R5 third entry", O_OPER);
        vcc_ge_on = 0; vcc_ge_sm = 0; vcc_lt_off = 1; step(1);
        chk("R8 supply fault to shutdown", O_SHUT);
        vcc_lt_refoff = 1; step(1);
        chk("R10 shutdown to startup", O_START);

        vcc_lt_refoff = 0; vcc_lt_off = 0; vcc_ge_sm = 1; vcc_ge_on = 1; step(2);
        chk("R2 startup to save again", O_SAVE0);
        vcc_ge_on = 0; vcc_ge_sm = 0; vcc_lt_off = 1; vcc_lt_refoff = 1;
        hsi = 1; step(1);
        chk("R10 save to startup", O_START);
        hsi = 0; step(6);
        chk("R10 startup holds after fall-back", O_START);

        finish_run();
    end

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired (all requirements): actual=hung expected=finished");
        finish_run();
    end
endmodule